// File: doc/BRIEF.md
# CAN Transmit Arbitration and Bit Monitor

This block supervises a single CAN node for as long as it is sending a frame. It sits between the frame serializer and the bus transceiver. At every sample-point strobe it compares the level it is driving with the level it reads back from the bus. The bus behaves as a wired-AND, so a dominant level (logic 0) from any node wins over a recessive level (logic 1). The serializer supplies the next bit and marks whether that bit belongs to the arbitration field or the acknowledge slot. The block judges each readback using those marks.

When a recessive bit comes back dominant during arbitration, the node has lost to a higher-priority frame. The block releases the bus without raising any error and keeps it released. The same overwrite in the acknowledge slot is the normal acknowledgement and is accepted. Any other mismatch is a bit error. On a bit error the block forces an error flag of six dominant bits onto the bus. It then releases the bus.

The block also gates the start of a frame. A frame may begin only once eleven consecutive recessive samples have been seen. After a lost arbitration or an error flag, the block waits for the bus to go idle again and then raises a retransmission request for one bit period.

Top module: `can_tx_supervisor`

## Requirements
- R1: After reset, `tx_drive` is 1 (recessive), and `arb_lost`, `bit_error`, `retry_req`, `busy` and `start_allowed` are all 0.
- R2: While not sending, `start_allowed` is 1 only once 11 consecutive sample ticks have read `rx_bit` = 1. Any sample with `rx_bit` = 0 restarts that count from zero.
- R3: Asserting `frame_active` while `start_allowed` is 0 has no effect: `tx_drive` stays 1 and `busy` stays 0.
- R4: While sending, `tx_drive` equals `tx_bit`. A sample whose `rx_bit` equals `tx_bit` raises neither `arb_lost` nor `bit_error`.
- R5: A sample with sent 1, read 0 and `in_arbitration` = 1 raises `arb_lost` and does not raise `bit_error`. From the next clock on, `tx_drive` stays 1 whatever `tx_bit` is, until the retry request has ended.
- R6: A sample with sent 1, read 0 and `in_ack_slot` = 1 (with `in_arbitration` = 0) raises no flag, and transmission continues.
- R7: A sample with sent 0 and read 1 raises `bit_error` in every field, including when `in_arbitration` = 1.
- R8: A sample with sent 1 and read 0, when both `in_arbitration` and `in_ack_slot` are 0, raises `bit_error`.
- R9: After `bit_error`, `tx_drive` is 0 for exactly the next 6 sample ticks, whatever `tx_bit` is. It is 1 afterwards.
- R10: After `arb_lost`, or after the error flag has ended, `retry_req` rises once 11 consecutive recessive samples have been seen. It stays high until the next sample tick and then falls. `busy` is 1 from the loss or error until that point.
- R11: `arb_lost` and `bit_error` are single-clock pulses, one clock after a sample tick, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-clock strobe at the sample point of each bit |
| tx_bit | input | 1 | Next bit from the serializer (0 = dominant) |
| rx_bit | input | 1 | Level read back from the bus (0 = dominant) |
| in_arbitration | input | 1 | Current bit lies in the arbitration field, stuff bits included |
| in_ack_slot | input | 1 | Current bit is the acknowledge slot |
| frame_active | input | 1 | Serializer wants to send, or is sending, a frame |
| tx_drive | output | 1 | Level driven toward the bus (0 = dominant) |
| start_allowed | output | 1 | Bus idle and block free, so a frame may begin |
| arb_lost | output | 1 | One-clock pulse: arbitration lost |
| bit_error | output | 1 | One-clock pulse: bit error detected |
| retry_req | output | 1 | Retransmission request, held for one bit period |
| busy | output | 1 | Block is transmitting, signalling or recovering |

## Verification
The hardest situation to reach is a readback fault that lands on a particular field while the block is sending. The verdict then has to carry the block through a whole recovery: six flag bits, a fresh idle window and the retry handshake, before the next frame can start. The stimulus builds random frames with random arbitration and acknowledge spans and injects overwrites at random bit positions. Directed cases pin down the exact tick on which the idle window closes and on which the error flag ends.

// File: rtl/can_sup_pkg.sv
package can_sup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_LOST,
        ST_FLAG,
        ST_RECOVER,
        ST_RETRY
    } sup_state_e;

    typedef enum logic [1:0] {
        V_OK,
        V_LOST,
        V_ERR
    } verdict_e;

    typedef struct packed {
        sup_state_e state;
        logic       lost;
        logic       err;
    } sup_regs_t;

endpackage

// File: rtl/can_bit_judge.sv
module can_bit_judge
    import can_sup_pkg::*;
(
    input  logic     sent,
    input  logic     seen,
    input  logic     in_arb,
    input  logic     in_ack,
    output verdict_e verdict
);

    always_comb begin
        verdict = V_OK;
        if (sent != seen) begin
            if (sent && in_arb) begin
                verdict = V_LOST;
            end else if (sent && in_ack) begin
                verdict = V_OK;
            end else begin
                verdict = V_ERR;
            end
        end
    end

endmodule

// File: rtl/can_idle_watch.sv
module can_idle_watch #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic rx_level,
    output logic bus_idle
);

    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (sample) begin
            if (!rx_level) begin
                cnt_d = '0;
            end else if (cnt_q != LIMIT) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign bus_idle = (cnt_q == LIMIT);

endmodule

// File: rtl/can_flag_counter.sv
module can_flag_counter #(
    parameter int FLAG_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CW = (FLAG_BITS > 1) ? $clog2(FLAG_BITS) : 1;
    localparam logic [CW-1:0] FINAL = CW'(FLAG_BITS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == FINAL);

endmodule

// File: rtl/can_tx_supervisor.sv
module can_tx_supervisor
    import can_sup_pkg::*;
#(
    parameter int IDLE_BITS = 11,
    parameter int FLAG_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic in_arbitration,
    input  logic in_ack_slot,
    input  logic frame_active,
    output logic tx_drive,
    output logic start_allowed,
    output logic arb_lost,
    output logic bit_error,
    output logic retry_req,
    output logic busy
);

    sup_regs_t r_d, r_q;
    verdict_e  verdict;
    logic      bus_idle;
    logic      sending;
    logic      flag_clear;
    logic      flag_step;
    logic      flag_last;

    can_idle_watch #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (bit_tick),
        .rx_level (rx_bit),
        .bus_idle (bus_idle)
    );

    can_flag_counter #(.FLAG_BITS(FLAG_BITS)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flag_clear),
        .step  (flag_step),
        .last  (flag_last)
    );

    can_bit_judge u_judge (
        .sent    (tx_drive),
        .seen    (rx_bit),
        .in_arb  (in_arbitration),
        .in_ack  (in_ack_slot),
        .verdict (verdict)
    );

    // Sending: either already in a frame, or starting one on a free bus.
    always_comb begin
        sending = (r_q.state == ST_TX) ||
                  ((r_q.state == ST_IDLE) && frame_active && bus_idle);
        sending = sending && frame_active;
    end

    always_comb begin
        if (sending) begin
            tx_drive = tx_bit;
        end else if (r_q.state == ST_FLAG) begin
            tx_drive = 1'b0;
        end else begin
            tx_drive = 1'b1;
        end
    end

    always_comb begin
        r_d        = r_q;
        r_d.lost   = 1'b0;
        r_d.err    = 1'b0;
        flag_clear = 1'b0;
        flag_step  = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_TX: begin
                if (!sending) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.state = ST_TX;
                    if (bit_tick) begin
                        unique case (verdict)
                            V_LOST: begin
                                r_d.state = ST_LOST;
                                r_d.lost  = 1'b1;
                            end
                            V_ERR: begin
                                r_d.state  = ST_FLAG;
                                r_d.err    = 1'b1;
                                flag_clear = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            ST_FLAG: begin
                if (bit_tick) begin
                    flag_step = 1'b1;
                    if (flag_last) begin
                        r_d.state = ST_RECOVER;
                    end
                end
            end
            ST_LOST, ST_RECOVER: begin
                if (bus_idle) begin
                    r_d.state = ST_RETRY;
                end
            end
            ST_RETRY: begin
                if (bit_tick) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.lost  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign arb_lost      = r_q.lost;
    assign bit_error     = r_q.err;
    assign retry_req     = (r_q.state == ST_RETRY);
    assign busy          = (r_q.state != ST_IDLE);
    assign start_allowed = (r_q.state == ST_IDLE) && bus_idle;

endmodule

// File: rtl/can_tx_supervisor_chk.sv
module can_tx_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_drive,
    input logic start_allowed,
    input logic arb_lost,
    input logic bit_error,
    input logic retry_req,
    input logic busy
);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_lost && bit_error));

    assert_lost_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> !arb_lost);

    assert_err_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_error |-> $past(bit_tick));

    assert_lost_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> tx_drive);

    assert_flag_dominant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_error |-> !tx_drive);

    assert_retry_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> busy);

    assert_start_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_allowed |-> !busy);

endmodule

bind can_tx_supervisor can_tx_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .tx_drive      (tx_drive),
    .start_allowed (start_allowed),
    .arb_lost      (arb_lost),
    .bit_error     (bit_error),
    .retry_req     (retry_req),
    .busy          (busy)
);

// File: tb/can_tx_supervisor_tb.sv
module can_tx_supervisor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic tx_bit = 1'b1;
    logic rx_bit = 1'b1;
    logic in_arbitration = 1'b0;
    logic in_ack_slot = 1'b0;
    logic frame_active = 1'b0;
    logic tx_drive, start_allowed, arb_lost, bit_error, retry_req, busy;

    int checks = 0;
    int errors = 0;
    logic lost_s, err_s;
    bit done = 0;

    always #2 clk = ~clk;

    can_tx_supervisor u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_tick       (bit_tick),
        .tx_bit         (tx_bit),
        .rx_bit         (rx_bit),
        .in_arbitration (in_arbitration),
        .in_ack_slot    (in_ack_slot),
        .frame_active   (frame_active),
        .tx_drive       (tx_drive),
        .start_allowed  (start_allowed),
        .arb_lost       (arb_lost),
        .bit_error      (bit_error),
        .retry_req      (retry_req),
        .busy           (busy)
    );

    // 0 = fine, 1 = arbitration lost, 2 = bit error
    function automatic int judge(input logic sent, input logic seen,
                                 input logic arb, input logic ack);
        if (sent == seen) return 0;
        if (sent && arb) return 1;
        if (sent && ack) return 0;
        return 2;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic t, input logic r, input logic a, input logic k);
        @(negedge clk);
        tx_bit = t; rx_bit = r; in_arbitration = a; in_ack_slot = k;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        lost_s = arb_lost;
        err_s  = bit_error;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic recover_check();
        idle_bits(10);
        chk("R10 no retry before idle window", retry_req, 0);
        chk("R10 busy while waiting", busy, 1);
        chk("R5 released while waiting", tx_drive, 1);
        idle_bits(1);
        chk("R10 retry after idle window", retry_req, 1);
        tick(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 retry ends after one tick", retry_req, 0);
        chk("R10 busy cleared", busy, 0);
    endtask

    task automatic flag_check();
        for (int i = 0; i < 6; i++) begin
            chk("R9 flag bit dominant", tx_drive, 0);
            tick($urandom_range(1), 1'b0, 1'b0, 1'b0);
        end
        chk("R9 released after six flag bits", tx_drive, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1
        chk("R1 tx_drive", tx_drive, 1);
        chk("R1 arb_lost", arb_lost, 0);
        chk("R1 bit_error", bit_error, 0);
        chk("R1 retry_req", retry_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 start_allowed", start_allowed, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: dominant sample restarts the count
        idle_bits(5);
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        idle_bits(10);
        chk("R2 not allowed after 10", start_allowed, 0);
        // R3: request without permission
        frame_active = 1'b1;
        tx_bit = 1'b0;
        @(negedge clk);
        chk("R3 stays recessive", tx_drive, 1);
        chk("R3 not busy", busy, 0);
        frame_active = 1'b0;
        idle_bits(1);
        chk("R2 allowed after 11", start_allowed, 1);

        // R4/R6: clean frame with acknowledge overwrite
        frame_active = 1'b1;
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 no flags on match", lost_s | err_s, 0);
        tick(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4 follows tx_bit", tx_drive, 1);
        tick(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R6 ack overwrite silent", lost_s | err_s, 0);
        chk("R6 still busy", busy, 1);
        frame_active = 1'b0;
        idle_bits(11);

        // R5: arbitration loss
        frame_active = 1'b1;
        tick(1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 arb_lost", lost_s, 1);
        chk("R5 no bit_error", err_s, 0);
        tx_bit = 1'b0;
        @(negedge clk);
        chk("R5 recessive despite tx_bit 0", tx_drive, 1);
        frame_active = 1'b0;
        recover_check();

        // R7: dominant sent, recessive read in arbitration
        idle_bits(1);
        frame_active = 1'b1;
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R7 bit_error in arbitration", err_s, 1);
        chk("R7 no arb_lost", lost_s, 0);
        frame_active = 1'b0;
        flag_check();
        recover_check();

        // R8: recessive overwrite outside arbitration and ack
        frame_active = 1'b1;
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 bit_error", err_s, 1);
        frame_active = 1'b0;
        flag_check();
        recover_check();

        // Random frames
        for (int f = 0; f < 40; f++) begin
            int len, arb_end, ack_pos, v;
            if (!start_allowed) idle_bits(11);
            frame_active = 1'b1;
            len = 8 + $urandom_range(20);
            arb_end = 1 + $urandom_range(5);
            ack_pos = len - 3;
            for (int b = 0; b < len; b++) begin
                logic t, r, a, k;
                t = $urandom_range(1);
                a = (b >= 1 && b <= arb_end);
                k = (b == ack_pos);
                r = t;
                if ($urandom_range(15) == 0) r = ~t;
                if (k && $urandom_range(1) == 0) r = 1'b0;
                @(negedge clk);
                tx_bit = t;
                #1;
                chk("R4 random drive", tx_drive, t);
                v = judge(t, r, a, k);
                tick(t, r, a, k);
                chk("R5 random lost", lost_s, (v == 1));
                chk("R8 random error", err_s, (v == 2));
                if (v != 0) begin
                    frame_active = 1'b0;
                    if (v == 2) flag_check();
                    recover_check();
                    break;
                end
            end
            frame_active = 1'b0;
            @(negedge clk);
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule